// File: doc/BRIEF.md
# Asynchronous-Control Output Macrocell

This block is a single programmable output cell of a small logic device. It receives a set of data product terms together with dedicated clear, set, clock and drive-enable terms from the logic array, plus a per-cell polarity bit. Device-wide controls are a shared active-low drive-enable pin and an active-low parallel load strobe. The cell drives a pad value and a tri-state enable, and it returns a feedback bit to the array.

The data terms are ORed and passed through a polarity XOR into a storage bit. The bit is captured on a rising edge of the cell's own clock term, so every cell can run from a different clock. Clear and set are level overrides. When both are asserted at once, the storage bit is skipped and the cell behaves as a combinational output. The pad buffer inverts, so a stored 0 shows as a high pin. The parallel load strobe writes the inverse of the pad level into the storage bit, but only while the cell is not driving its pad.

The block runs on a system clock `clk`. The clock term is sampled on that clock and its rising transitions are detected there. Clear, set, bypass and load act on the outputs in the same cycle and are also written into the storage bit at the next `clk` edge. `rst_n` models the power-up reset.

Top module: `async_out_macrocell`

## Requirements
- R1: `pad_oe` is 1 exactly when `oe_term` is 1 and `oe_all_n` is 0; a high `oe_all_n` forces `pad_oe` to 0 whatever `oe_term` is.
- R2: While `rst_n` is low, and after its release with no override active, the storage bit is 0: `array_fb` = 0 and `pad_out` = 1.
- R3: The captured value is (OR of all `sum_terms` bits) XOR `pol_cfg`. A `clk_term` sample of 1 following a sample of 0 captures that value at the same `clk` edge, and in normal mode `array_fb` shows it from the next cycle, with `pad_out` equal to its inverse. With `pol_cfg` = 1 the pin is therefore active high.
- R4: In normal mode (`load_all_n`=1, `clr_term`=0, `set_term`=0), `array_fb` does not change unless `clk_term` rises. Holding `clk_term` high captures only once.
- R5: With `clr_term`=1, `set_term`=0 and `load_all_n`=1, `array_fb` = 0 and `pad_out` = 1 in the same cycle. The value 0 remains after `clr_term` is released until the next capture.
- R6: With `set_term`=1, `clr_term`=0 and `load_all_n`=1, `array_fb` = 1 and `pad_out` = 0 in the same cycle. The value 1 remains after `set_term` is released until the next capture.
- R7: With `clr_term`=1, `set_term`=1 and `load_all_n`=1, the cell is combinational: `array_fb` equals the R3 value in the same cycle, `pad_out` is its inverse, and the stored bit is unchanged when bypass ends.
- R8: A clear or set that is active in the cycle of a `clk_term` rising edge wins: the stored bit takes the override value, not the captured data.
- R9: While `load_all_n`=0 and `pad_oe`=0, the storage bit takes the inverse of `pad_in` (`array_fb` = NOT `pad_in` in the same cycle). This has priority over the clear, set and clock terms and holds after the strobe ends.
- R10: While `load_all_n`=0 and `pad_oe`=1, the storage bit keeps its value whatever `pad_in` is.
- R11: `pol_cfg` has no effect on the results of clear, set or parallel load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the clock term is sampled on its rising edge |
| rst_n | input | 1 | Active-low power-up reset |
| sum_terms | input | N_TERMS | Data product terms, ORed into the data input |
| clr_term | input | 1 | Level clear term (storage bit to 0) |
| set_term | input | 1 | Level set term (storage bit to 1) |
| clk_term | input | 1 | Per-cell clock term, rising-edge active |
| oe_term | input | 1 | Per-cell drive-enable term |
| pol_cfg | input | 1 | Polarity bit XORed into the data input |
| oe_all_n | input | 1 | Shared active-low drive enable |
| load_all_n | input | 1 | Shared active-low parallel load strobe |
| pad_in | input | 1 | Level present on the pad |
| pad_out | output | 1 | Value the pad buffer drives (inverted storage bit) |
| pad_oe | output | 1 | Tri-state enable of the pad buffer |
| array_fb | output | 1 | Feedback bit to the array |

## Verification
The clock-term capture can fall in the same cycle as an override: a clear, a set, bypass or the parallel load strobe. The bench provokes this by raising `clk_term` in the cycle that asserts `clr_term` or `set_term`, with data chosen to give the opposite value. It then releases both and reads `array_fb` one cycle later, after the override has gone. It also puts the load strobe on top of an active clear, and enables the drive during a load. In each case the result is judged against the override value, or against the value stored before the load, not against the data.

// File: rtl/omc_pkg.sv
package omc_pkg;

    typedef enum logic [2:0] {
        MODE_NORMAL  = 3'd0,
        MODE_CLEAR   = 3'd1,
        MODE_SET     = 3'd2,
        MODE_BYPASS  = 3'd3,
        MODE_PL_LOAD = 3'd4,
        MODE_PL_HOLD = 3'd5
    } cell_mode_e;

    typedef struct packed {
        logic ff;       // storage bit (before the inverting buffer)
        logic clk_lvl;  // last sampled level of the clock term
    } cell_state_t;

    // Clock memory starts high so a term already high at release is no edge.
    localparam cell_state_t STATE_RESET = '{ff: 1'b0, clk_lvl: 1'b1};

endpackage

// File: rtl/omc_sum_xor.sv
module omc_sum_xor #(
    parameter int N_TERMS = 4
) (
    input  logic [N_TERMS-1:0] terms_i,
    input  logic               pol_i,
    output logic               d_o
);

    logic [N_TERMS:0] or_chain;

    assign or_chain[0] = 1'b0;

    generate
        for (genvar i = 0; i < N_TERMS; i++) begin : g_or
            assign or_chain[i+1] = or_chain[i] | terms_i[i];
        end
    endgenerate

    assign d_o = or_chain[N_TERMS] ^ pol_i;

endmodule

// File: rtl/omc_mode_dec.sv
module omc_mode_dec
    import omc_pkg::*;
(
    input  logic       clr_i,
    input  logic       set_i,
    input  logic       load_n_i,
    input  logic       drive_en_i,
    output cell_mode_e mode_o
);

    // Priority: parallel load, then bypass, then clear, then set.
    always_comb begin
        if (!load_n_i) begin
            mode_o = drive_en_i ? MODE_PL_HOLD : MODE_PL_LOAD;
        end else if (clr_i && set_i) begin
            mode_o = MODE_BYPASS;
        end else if (clr_i) begin
            mode_o = MODE_CLEAR;
        end else if (set_i) begin
            mode_o = MODE_SET;
        end else begin
            mode_o = MODE_NORMAL;
        end
    end

endmodule

// File: rtl/omc_pad_drv.sv
module omc_pad_drv (
    input  logic oe_term_i,
    input  logic oe_all_n_i,
    input  logic value_i,
    output logic pad_out_o,
    output logic pad_oe_o
);

    assign pad_oe_o  = oe_term_i & ~oe_all_n_i;
    assign pad_out_o = ~value_i;

endmodule

// File: rtl/async_out_macrocell.sv
module async_out_macrocell
    import omc_pkg::*;
#(
    parameter int N_TERMS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_TERMS-1:0] sum_terms,
    input  logic               clr_term,
    input  logic               set_term,
    input  logic               clk_term,
    input  logic               oe_term,
    input  logic               pol_cfg,
    input  logic               oe_all_n,
    input  logic               load_all_n,
    input  logic               pad_in,
    output logic               pad_out,
    output logic               pad_oe,
    output logic               array_fb
);

    cell_state_t state_d, state_q;
    cell_mode_e  mode;
    logic        d_val;
    logic        rise;
    logic        eff_val;
    logic        drive_en;
    logic        pad_val;

    omc_sum_xor #(.N_TERMS(N_TERMS)) u_sum (
        .terms_i (sum_terms),
        .pol_i   (pol_cfg),
        .d_o     (d_val)
    );

    omc_pad_drv u_pad (
        .oe_term_i  (oe_term),
        .oe_all_n_i (oe_all_n),
        .value_i    (eff_val),
        .pad_out_o  (pad_val),
        .pad_oe_o   (drive_en)
    );

    omc_mode_dec u_mode (
        .clr_i      (clr_term),
        .set_i      (set_term),
        .load_n_i   (load_all_n),
        .drive_en_i (drive_en),
        .mode_o     (mode)
    );

    always_comb begin
        state_d         = state_q;
        state_d.clk_lvl = clk_term;
        rise            = clk_term & ~state_q.clk_lvl;

        unique case (mode)
            MODE_PL_LOAD: state_d.ff = ~pad_in;
            MODE_CLEAR:   state_d.ff = 1'b0;
            MODE_SET:     state_d.ff = 1'b1;
            MODE_PL_HOLD,
            MODE_BYPASS:  state_d.ff = state_q.ff;
            default: begin
                if (rise) begin
                    state_d.ff = d_val;
                end
            end
        endcase

        // Overrides show at once; normal and held modes show the stored bit.
        unique case (mode)
            MODE_BYPASS:  eff_val = d_val;
            MODE_NORMAL,
            MODE_PL_HOLD: eff_val = state_q.ff;
            default:      eff_val = state_d.ff;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= STATE_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    assign pad_out  = pad_val;
    assign pad_oe   = drive_en;
    assign array_fb = eff_val;

endmodule

// File: rtl/async_out_macrocell_chk.sv
module async_out_macrocell_chk #(
    parameter int N_TERMS = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_TERMS-1:0] sum_terms,
    input logic               clr_term,
    input logic               set_term,
    input logic               clk_term,
    input logic               oe_term,
    input logic               pol_cfg,
    input logic               oe_all_n,
    input logic               load_all_n,
    input logic               pad_in,
    input logic               pad_out,
    input logic               pad_oe,
    input logic               array_fb
);

    logic norm;
    logic dexp;

    assign norm = load_all_n && !clr_term && !set_term;
    assign dexp = (|sum_terms) ^ pol_cfg;

    // R1
    a_r1_common_disable: assert property (@(posedge clk) disable iff (!rst_n)
        oe_all_n |-> !pad_oe);
    a_r1_both_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_term && !oe_all_n) |-> pad_oe);

    // R3
    a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (norm && clk_term && !$past(clk_term) && $past(rst_n))
        |=> (norm -> (array_fb == $past(dexp))));

    // R4
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (norm && !clk_term) |=> (norm -> $stable(array_fb)));

    // R5
    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (load_all_n && clr_term && !set_term) |-> (!array_fb && pad_out));

    // R6
    a_r6_set: assert property (@(posedge clk) disable iff (!rst_n)
        (load_all_n && set_term && !clr_term) |-> (array_fb && !pad_out));

    // R7
    a_r7_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (load_all_n && clr_term && set_term) |-> ((array_fb == dexp) && (pad_out == !dexp)));

    // R9
    a_r9_preload: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_all_n && !pad_oe) |-> ((array_fb == !pad_in) && (pad_out == pad_in)));

    // R10
    a_r10_preload_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_all_n && pad_oe) |=> ((!load_all_n && pad_oe) -> $stable(array_fb)));

endmodule

bind async_out_macrocell async_out_macrocell_chk #(.N_TERMS(N_TERMS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sum_terms  (sum_terms),
    .clr_term   (clr_term),
    .set_term   (set_term),
    .clk_term   (clk_term),
    .oe_term    (oe_term),
    .pol_cfg    (pol_cfg),
    .oe_all_n   (oe_all_n),
    .load_all_n (load_all_n),
    .pad_in     (pad_in),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe),
    .array_fb   (array_fb)
);

// File: tb/async_out_macrocell_tb.sv
module async_out_macrocell_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N_TERMS    = 4;
    localparam int WATCHDOG   = 20000;

    logic               clk = 1'b0;
    logic               rst_n;
    logic [N_TERMS-1:0] sum_terms;
    logic               clr_term, set_term, clk_term, oe_term, pol_cfg;
    logic               oe_all_n, load_all_n, pad_in;
    logic               pad_out, pad_oe, array_fb;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    async_out_macrocell #(.N_TERMS(N_TERMS)) u_dut (
        .clk(clk), .rst_n(rst_n), .sum_terms(sum_terms),
        .clr_term(clr_term), .set_term(set_term), .clk_term(clk_term),
        .oe_term(oe_term), .pol_cfg(pol_cfg), .oe_all_n(oe_all_n),
        .load_all_n(load_all_n), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .array_fb(array_fb)
    );

    function automatic logic dexp(input logic [N_TERMS-1:0] t, input logic p);
        return (|t) ^ p;
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // Store value s through a normal capture (R3 path).
    task automatic store(input logic s);
        clk_term = 1'b0;
        step(1);
        sum_terms = s ? 4'b0001 : 4'b0000;
        pol_cfg   = 1'b0;
        clk_term  = 1'b1;
        step(1);
        clk_term  = 1'b0;
        step(1);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
        $finish;
    end

    initial begin
        rst_n = 1'b0; sum_terms = '0; clr_term = 0; set_term = 0; clk_term = 0;
        oe_term = 1; pol_cfg = 0; oe_all_n = 0; load_all_n = 1; pad_in = 0;
        @(negedge clk);
        step(2);
        chk("R2 fb in reset", array_fb, 1'b0);
        chk("R2 pad in reset", pad_out, 1'b1);
        rst_n = 1'b1;
        step(2);
        chk("R2 fb after reset", array_fb, 1'b0);
        chk("R2 pad after reset", pad_out, 1'b1);

        // R1: enable gating sweep
        for (int i = 0; i < 4; i++) begin
            oe_term = i[0]; oe_all_n = i[1];
            #1;
            chk("R1 pad_oe", pad_oe, i[0] & ~i[1]);
        end
        oe_term = 1; oe_all_n = 0;

        // R3: capture sweep over polarity and all data patterns
        for (int p = 0; p < 2; p++) begin
            for (int t = 0; t < 16; t++) begin
                clk_term = 1'b0;
                step(1);
                sum_terms = t[3:0]; pol_cfg = p[0]; clk_term = 1'b1;
                step(1);
                clk_term = 1'b0;
                chk("R3 fb capture", array_fb, dexp(t[3:0], p[0]));
                chk("R3 pad capture", pad_out, ~dexp(t[3:0], p[0]));
            end
        end

        // R4: no edge -> hold; level held high captures once
        store(1'b1);
        sum_terms = 4'b0000; pol_cfg = 0;
        step(3);
        chk("R4 hold low clock", array_fb, 1'b1);
        clk_term = 1'b1; sum_terms = 4'b0000;
        step(1);
        chk("R4 first capture", array_fb, 1'b0);
        sum_terms = 4'b1000;
        step(3);
        chk("R4 level high no recapture", array_fb, 1'b0);
        clk_term = 1'b0;
        step(1);

        // R5, R6, R11: clear/set levels and persistence, both polarities
        for (int p = 0; p < 2; p++) begin
            store(1'b1);
            pol_cfg = p[0]; clr_term = 1'b1;
            #1;
            chk("R5 clear same cycle", array_fb, 1'b0);
            chk("R5 clear pad high", pad_out, 1'b1);
            step(1);
            clr_term = 1'b0;
            step(2);
            chk("R5 R11 clear persists", array_fb, 1'b0);
            set_term = 1'b1;
            #1;
            chk("R6 set same cycle", array_fb, 1'b1);
            chk("R6 set pad low", pad_out, 1'b0);
            step(1);
            set_term = 1'b0;
            step(2);
            chk("R6 R11 set persists", array_fb, 1'b1);
        end

        // R8: override wins over a simultaneous clock edge
        store(1'b0);
        clk_term = 1'b0;
        step(1);
        sum_terms = 4'b0001; pol_cfg = 0; clk_term = 1'b1; clr_term = 1'b1;
        step(1);
        clr_term = 1'b0; clk_term = 1'b0;
        step(1);
        chk("R8 clear beats edge", array_fb, 1'b0);
        sum_terms = 4'b0000; clk_term = 1'b1; set_term = 1'b1;
        step(1);
        set_term = 1'b0; clk_term = 1'b0;
        step(1);
        chk("R8 set beats edge", array_fb, 1'b1);

        // R7: bypass sweep, stored bit untouched afterwards
        store(1'b1);
        clr_term = 1'b1; set_term = 1'b1;
        for (int p = 0; p < 2; p++) begin
            for (int t = 0; t < 16; t++) begin
                sum_terms = t[3:0]; pol_cfg = p[0];
                #1;
                chk("R7 bypass fb", array_fb, dexp(t[3:0], p[0]));
                chk("R7 bypass pad", pad_out, ~dexp(t[3:0], p[0]));
                step(1);
            end
        end
        clr_term = 1'b0; set_term = 1'b0;
        #1;
        chk("R7 stored bit kept", array_fb, 1'b1);
        step(1);

        // R9, R11: preload with output disabled; also over an active clear
        oe_term = 1'b0;
        for (int p = 0; p < 2; p++) begin
            for (int v = 0; v < 2; v++) begin
                store(v[0]);
                pol_cfg = p[0]; pad_in = v[0]; load_all_n = 1'b0;
                #1;
                chk("R9 preload same cycle", array_fb, ~v[0]);
                step(1);
                load_all_n = 1'b1;
                step(2);
                chk("R9 R11 preload holds", array_fb, ~v[0]);
                chk("R9 pad after preload", pad_out, v[0]);
            end
        end
        store(1'b0);
        clr_term = 1'b1; pad_in = 1'b0; load_all_n = 1'b0;
        #1;
        chk("R9 preload over clear", array_fb, 1'b1);
        step(1);
        load_all_n = 1'b1; clr_term = 1'b0;
        step(1);
        chk("R9 preload over clear kept", array_fb, 1'b1);

        // R10: preload with output enabled keeps state
        oe_term = 1'b1; oe_all_n = 1'b0;
        for (int v = 0; v < 2; v++) begin
            store(v[0]);
            pad_in = v[0]; load_all_n = 1'b0;
            step(2);
            chk("R10 enabled preload ignored", array_fb, v[0]);
            load_all_n = 1'b1;
            step(1);
            chk("R10 state after strobe", array_fb, v[0]);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule